// File: doc/BRIEF.md
# Prioritized Interrupt Entry Controller

This block sits beside a 16-bit processor core and decides when one of two interrupt sources may break into the running program. The two sources are a serial transmit request, which is a level input, and a periodic timer that the block keeps itself. The timer counts execution steps reported by the core. Each source takes its 3-bit priority from a field inside its own 8-bit priority register. The winning priority is compared with the 3-bit mask held in the core's status word, and a request is taken only if its priority is strictly above the mask.

On acceptance the controller saves the status word and then the program counter on the stack below the current stack pointer. It does this as four byte writes through a simple memory port. It then hands the core the handler address supplied for the winning source, the updated stack pointer, and the vector-table address of that source. A return request reverses the sequence: it reads the program counter and then the status word back from the stack and hands them to the core.

An active-depth counter records that a handler is running. While this counter is nonzero, no new entry is accepted.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After reset the memory port is inactive, all load and write strobes are low, busy is low and the depth counter is zero.
- R2: The serial transmit priority is bits 6:4 of its priority register and the timer priority is bits 6:4 of the other; bit 7 and bits 3:0 of either register have no effect.
- R3: A pending request is accepted only when its priority is strictly greater than bits 10:8 of the status word; an equal or lower priority leaves the block idle.
- R4: When both sources are pending, the one with the higher priority is taken; on equal priorities the serial transmit source is taken.
- R5: The timer becomes pending after PERIOD step pulses and stays pending until the timer interrupt itself is taken, which clears the step count; taking the serial source does not clear it.
- R6: Entry performs exactly four byte writes with busy high during them, in this order: status high byte to SP-2, status low byte to SP-1, program counter high byte to SP-4, program counter low byte to SP-3.
- R7: In the cycle after the last entry write, the program-counter load strobe is high with the winning source's handler input, the stack-pointer write strobe is high with SP-4, and the vector-table address output is 0x0042 for the timer and 0x0084 for serial transmit.
- R8: Entry raises the depth counter by one, and no entry is accepted while the depth counter is nonzero.
- R9: A return reads bytes from SP, SP+1 (program counter, high byte first), then SP+2 and SP+3 (status word), with read data arriving one cycle after each read strobe. It then pulses both load strobes with these values together with the stack-pointer write of SP+4. It lowers the depth counter by one, but never below zero.
- R10: A return request in an idle cycle is served before any interrupt that is acceptable in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | One pulse per executed core step; advances the timer count |
| tx_req_i | input | 1 | Serial transmit interrupt request level |
| pri_tx_i | input | 8 | Serial transmit priority register (priority in bits 6:4) |
| pri_tmr_i | input | 8 | Timer priority register (priority in bits 6:4) |
| sr_i | input | 16 | Current status word (mask in bits 10:8) |
| pc_i | input | 16 | Program counter to save on entry |
| sp_i | input | 16 | Current stack pointer (register 7) |
| vec_tx_i | input | 16 | Handler address for serial transmit |
| vec_tmr_i | input | 16 | Handler address for the timer |
| rti_i | input | 1 | Return-from-handler request pulse |
| mem_we_o | output | 1 | Memory byte write strobe |
| mem_re_o | output | 1 | Memory byte read strobe |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid the cycle after mem_re_o |
| busy_o | output | 1 | High during the four entry writes |
| pc_load_o | output | 1 | Load pc_o into the program counter |
| pc_o | output | 16 | New program counter value |
| sr_load_o | output | 1 | Load sr_o into the status word |
| sr_o | output | 16 | Restored status word |
| sp_wr_o | output | 1 | Write sp_o into the stack pointer |
| sp_o | output | 16 | New stack pointer value |
| vec_addr_o | output | 16 | Vector-table address of the source being entered |
| depth_o | output | DEPTH_W | Active handler depth |

## Verification
The assertions take for granted that the core keeps sp_i, sr_i and pc_i steady from the acceptance cycle until the controller's final strobe. They also assume that rti_i is raised only when the core would actually execute a return, and that mem_rdata_i follows the one-cycle read latency. The stimulus changes these inputs only between complete entry and return sequences. It pulses rti_i for a single idle cycle and adopts each reported stack pointer before the next sequence starts. The bench's memory model answers reads on the following edge.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned BYTE_W = 8;

    localparam logic [WORD_W-1:0] TMR_VEC_ADDR = 16'h0042;
    localparam logic [WORD_W-1:0] TX_VEC_ADDR  = 16'h0084;

    typedef enum logic {
        SRC_TX  = 1'b0,
        SRC_TMR = 1'b1
    } irq_src_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH0,
        ST_PUSH1,
        ST_PUSH2,
        ST_PUSH3,
        ST_ENTER,
        ST_POP0,
        ST_POP1,
        ST_POP2,
        ST_POP3,
        ST_POPL,
        ST_RET
    } seq_state_e;

endpackage

// File: rtl/irq_step_timer.sv
module irq_step_timer #(
    parameter int unsigned PERIOD = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    input  logic clear_i,
    output logic pending_o
);
    localparam int unsigned CNT_W = $clog2(PERIOD + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(PERIOD);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.cnt = '0;
        end else if (step_i && (st_q.cnt < LIMIT)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending_o = (st_q.cnt >= LIMIT);

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import irq_entry_pkg::*;
#(
    parameter int unsigned REG_W    = 8,
    parameter int unsigned PRI_W    = 3,
    parameter int unsigned PRI_LSB  = 4,
    parameter int unsigned MASK_LSB = 8
) (
    input  logic              tx_req_i,
    input  logic              tmr_req_i,
    input  logic [REG_W-1:0]  pri_tx_i,
    input  logic [REG_W-1:0]  pri_tmr_i,
    input  logic [WORD_W-1:0] sr_i,
    output logic              grant_o,
    output irq_src_e          src_o
);
    logic [PRI_W-1:0] lvl_tx, lvl_tmr, lvl_win, lvl_mask;

    always_comb begin
        lvl_tx   = pri_tx_i[PRI_LSB +: PRI_W];
        lvl_tmr  = pri_tmr_i[PRI_LSB +: PRI_W];
        lvl_mask = sr_i[MASK_LSB +: PRI_W];
        // serial transmit keeps the grant on a tie
        if (tmr_req_i && (!tx_req_i || (lvl_tmr > lvl_tx))) begin
            src_o   = SRC_TMR;
            lvl_win = lvl_tmr;
        end else begin
            src_o   = SRC_TX;
            lvl_win = lvl_tx;
        end
        grant_o = (tx_req_i || tmr_req_i) && (lvl_win > lvl_mask);
    end

endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
    import irq_entry_pkg::*;
#(
    parameter int unsigned DEPTH_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               grant_i,
    input  irq_src_e           src_i,
    input  logic               rti_i,
    input  logic [WORD_W-1:0]  sr_i,
    input  logic [WORD_W-1:0]  pc_i,
    input  logic [WORD_W-1:0]  sp_i,
    input  logic [WORD_W-1:0]  vec_tx_i,
    input  logic [WORD_W-1:0]  vec_tmr_i,
    input  logic [BYTE_W-1:0]  mem_rdata_i,
    output logic               take_tmr_o,
    output logic               mem_we_o,
    output logic               mem_re_o,
    output logic [WORD_W-1:0]  mem_addr_o,
    output logic [BYTE_W-1:0]  mem_wdata_o,
    output logic               busy_o,
    output logic               pc_load_o,
    output logic [WORD_W-1:0]  pc_o,
    output logic               sr_load_o,
    output logic [WORD_W-1:0]  sr_o,
    output logic               sp_wr_o,
    output logic [WORD_W-1:0]  sp_o,
    output logic [WORD_W-1:0]  vec_addr_o,
    output logic [DEPTH_W-1:0] depth_o
);
    localparam logic [WORD_W-1:0]  OFS1 = WORD_W'(1);
    localparam logic [WORD_W-1:0]  OFS2 = WORD_W'(2);
    localparam logic [WORD_W-1:0]  OFS3 = WORD_W'(3);
    localparam logic [WORD_W-1:0]  OFS4 = WORD_W'(4);
    localparam logic [DEPTH_W-1:0] DEPTH_MAX = '1;

    typedef struct packed {
        seq_state_e         state;
        logic [WORD_W-1:0]  base;   // stack pointer at start of sequence
        logic [WORD_W-1:0]  wa;     // saved status on entry, popped pc on return
        logic [WORD_W-1:0]  wb;     // saved pc on entry, popped status on return
        logic [WORD_W-1:0]  vec;
        logic [WORD_W-1:0]  vaddr;
        logic [DEPTH_W-1:0] depth;
    } seq_t;

    seq_t sq_d, sq_q;
    logic accept;

    always_comb begin
        sq_d       = sq_q;
        accept     = 1'b0;
        take_tmr_o = 1'b0;
        unique case (sq_q.state)
            ST_IDLE: begin
                if (rti_i) begin
                    sq_d.base  = sp_i;
                    sq_d.state = ST_POP0;
                end else if (grant_i && (sq_q.depth == '0)) begin
                    accept     = 1'b1;
                    take_tmr_o = (src_i == SRC_TMR);
                    sq_d.base  = sp_i;
                    sq_d.wa    = sr_i;
                    sq_d.wb    = pc_i;
                    sq_d.vec   = (src_i == SRC_TMR) ? vec_tmr_i : vec_tx_i;
                    sq_d.vaddr = (src_i == SRC_TMR) ? TMR_VEC_ADDR : TX_VEC_ADDR;
                    sq_d.state = ST_PUSH0;
                end
            end
            ST_PUSH0: sq_d.state = ST_PUSH1;
            ST_PUSH1: sq_d.state = ST_PUSH2;
            ST_PUSH2: sq_d.state = ST_PUSH3;
            ST_PUSH3: sq_d.state = ST_ENTER;
            ST_ENTER: begin
                if (sq_q.depth != DEPTH_MAX) begin
                    sq_d.depth = sq_q.depth + 1'b1;
                end
                sq_d.state = ST_IDLE;
            end
            ST_POP0: sq_d.state = ST_POP1;
            ST_POP1: begin
                sq_d.wa[15:8] = mem_rdata_i;
                sq_d.state    = ST_POP2;
            end
            ST_POP2: begin
                sq_d.wa[7:0] = mem_rdata_i;
                sq_d.state   = ST_POP3;
            end
            ST_POP3: begin
                sq_d.wb[15:8] = mem_rdata_i;
                sq_d.state    = ST_POPL;
            end
            ST_POPL: begin
                sq_d.wb[7:0] = mem_rdata_i;
                sq_d.state   = ST_RET;
            end
            ST_RET: begin
                if (sq_q.depth != '0) begin
                    sq_d.depth = sq_q.depth - 1'b1;
                end
                sq_d.state = ST_IDLE;
            end
            default: sq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q       <= '0;
            sq_q.state <= ST_IDLE;
        end else begin
            sq_q <= sq_d;
        end
    end

    // Moore outputs decoded from the registered state
    always_comb begin
        mem_we_o    = 1'b0;
        mem_re_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        busy_o      = 1'b0;
        pc_load_o   = 1'b0;
        pc_o        = '0;
        sr_load_o   = 1'b0;
        sr_o        = '0;
        sp_wr_o     = 1'b0;
        sp_o        = '0;
        vec_addr_o  = '0;
        unique case (sq_q.state)
            ST_PUSH0: begin
                mem_we_o = 1'b1; mem_addr_o = sq_q.base - OFS2; mem_wdata_o = sq_q.wa[15:8];
            end
            ST_PUSH1: begin
                mem_we_o = 1'b1; mem_addr_o = sq_q.base - OFS1; mem_wdata_o = sq_q.wa[7:0];
            end
            ST_PUSH2: begin
                mem_we_o = 1'b1; mem_addr_o = sq_q.base - OFS4; mem_wdata_o = sq_q.wb[15:8];
            end
            ST_PUSH3: begin
                mem_we_o = 1'b1; mem_addr_o = sq_q.base - OFS3; mem_wdata_o = sq_q.wb[7:0];
            end
            ST_ENTER: begin
                pc_load_o  = 1'b1; pc_o = sq_q.vec;
                sp_wr_o    = 1'b1; sp_o = sq_q.base - OFS4;
                vec_addr_o = sq_q.vaddr;
            end
            ST_POP0: begin mem_re_o = 1'b1; mem_addr_o = sq_q.base;        end
            ST_POP1: begin mem_re_o = 1'b1; mem_addr_o = sq_q.base + OFS1; end
            ST_POP2: begin mem_re_o = 1'b1; mem_addr_o = sq_q.base + OFS2; end
            ST_POP3: begin mem_re_o = 1'b1; mem_addr_o = sq_q.base + OFS3; end
            ST_RET: begin
                pc_load_o = 1'b1; pc_o = sq_q.wa;
                sr_load_o = 1'b1; sr_o = sq_q.wb;
                sp_wr_o   = 1'b1; sp_o = sq_q.base + OFS4;
            end
            default: ;
        endcase
        busy_o = (sq_q.state == ST_PUSH0) || (sq_q.state == ST_PUSH1) ||
                 (sq_q.state == ST_PUSH2) || (sq_q.state == ST_PUSH3);
    end

    assign depth_o = sq_q.depth;

    logic unused_accept;
    assign unused_accept = accept;

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_entry_pkg::*;
#(
    parameter int unsigned PERIOD  = 2048,
    parameter int unsigned DEPTH_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_i,
    input  logic               tx_req_i,
    input  logic [7:0]         pri_tx_i,
    input  logic [7:0]         pri_tmr_i,
    input  logic [15:0]        sr_i,
    input  logic [15:0]        pc_i,
    input  logic [15:0]        sp_i,
    input  logic [15:0]        vec_tx_i,
    input  logic [15:0]        vec_tmr_i,
    input  logic               rti_i,
    output logic               mem_we_o,
    output logic               mem_re_o,
    output logic [15:0]        mem_addr_o,
    output logic [7:0]         mem_wdata_o,
    input  logic [7:0]         mem_rdata_i,
    output logic               busy_o,
    output logic               pc_load_o,
    output logic [15:0]        pc_o,
    output logic               sr_load_o,
    output logic [15:0]        sr_o,
    output logic               sp_wr_o,
    output logic [15:0]        sp_o,
    output logic [15:0]        vec_addr_o,
    output logic [DEPTH_W-1:0] depth_o
);
    logic     tmr_pending;
    logic     take_tmr;
    logic     grant;
    irq_src_e src;

    irq_step_timer #(.PERIOD(PERIOD)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step_i),
        .clear_i   (take_tmr),
        .pending_o (tmr_pending)
    );

    irq_prio_arbiter #(
        .REG_W    (8),
        .PRI_W    (3),
        .PRI_LSB  (4),
        .MASK_LSB (8)
    ) u_arb (
        .tx_req_i  (tx_req_i),
        .tmr_req_i (tmr_pending),
        .pri_tx_i  (pri_tx_i),
        .pri_tmr_i (pri_tmr_i),
        .sr_i      (sr_i),
        .grant_o   (grant),
        .src_o     (src)
    );

    irq_stack_seq #(.DEPTH_W(DEPTH_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant_i     (grant),
        .src_i       (src),
        .rti_i       (rti_i),
        .sr_i        (sr_i),
        .pc_i        (pc_i),
        .sp_i        (sp_i),
        .vec_tx_i    (vec_tx_i),
        .vec_tmr_i   (vec_tmr_i),
        .mem_rdata_i (mem_rdata_i),
        .take_tmr_o  (take_tmr),
        .mem_we_o    (mem_we_o),
        .mem_re_o    (mem_re_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .busy_o      (busy_o),
        .pc_load_o   (pc_load_o),
        .pc_o        (pc_o),
        .sr_load_o   (sr_load_o),
        .sr_o        (sr_o),
        .sp_wr_o     (sp_wr_o),
        .sp_o        (sp_o),
        .vec_addr_o  (vec_addr_o),
        .depth_o     (depth_o)
    );

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
    parameter int unsigned DEPTH_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mem_we_o,
    input logic               mem_re_o,
    input logic               busy_o,
    input logic               pc_load_o,
    input logic               sr_load_o,
    input logic               sp_wr_o,
    input logic [15:0]        vec_addr_o,
    input logic [DEPTH_W-1:0] depth_o
);
    assert_we_only_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);

    assert_no_rw_clash_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o));

    assert_no_nest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(depth_o) == '0));

    assert_enter_follows_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (pc_load_o && sp_wr_o && !sr_load_o));

    assert_vec_addr_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load_o && !sr_load_o) |-> ((vec_addr_o == 16'h0042) || (vec_addr_o == 16'h0084)));

    assert_depth_inc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load_o && !sr_load_o) |=> (depth_o == DEPTH_W'($past(depth_o) + 1'b1)));

    assert_depth_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_load_o && (depth_o == '0)) |=> (depth_o == '0));

    assert_depth_dec_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_load_o && (depth_o != '0)) |=> (depth_o == DEPTH_W'($past(depth_o) - 1'b1)));

    assert_ret_strobes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sr_load_o |-> (pc_load_o && sp_wr_o && !mem_re_o));

endmodule

bind irq_entry_ctrl irq_entry_chk #(.DEPTH_W(DEPTH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_we_o   (mem_we_o),
    .mem_re_o   (mem_re_o),
    .busy_o     (busy_o),
    .pc_load_o  (pc_load_o),
    .sr_load_o  (sr_load_o),
    .sp_wr_o    (sp_wr_o),
    .vec_addr_o (vec_addr_o),
    .depth_o    (depth_o)
);

// File: tb/irq_entry_ctrl_tb.sv
`timescale 1ns/1ps
module irq_entry_ctrl_tb;
    localparam int unsigned PERIOD  = 20;
    localparam int unsigned DEPTH_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_i = 1'b0, tx_req_i = 1'b0, rti_i = 1'b0;
    logic [7:0]  pri_tx_i = '0, pri_tmr_i = '0;
    logic [15:0] sr_i = '0, pc_i = '0, sp_i = 16'h00C0;
    logic [15:0] vec_tx_i = 16'h3A10, vec_tmr_i = 16'h5C20;
    logic mem_we_o, mem_re_o, busy_o, pc_load_o, sr_load_o, sp_wr_o;
    logic [15:0] mem_addr_o, pc_o, sr_o, sp_o, vec_addr_o;
    logic [7:0]  mem_wdata_o;
    logic [7:0]  mem_rdata_i = '0;
    logic [DEPTH_W-1:0] depth_o;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] mem [0:255];

    always #2 clk = ~clk;

    irq_entry_ctrl #(.PERIOD(PERIOD), .DEPTH_W(DEPTH_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .tx_req_i(tx_req_i),
        .pri_tx_i(pri_tx_i), .pri_tmr_i(pri_tmr_i), .sr_i(sr_i), .pc_i(pc_i),
        .sp_i(sp_i), .vec_tx_i(vec_tx_i), .vec_tmr_i(vec_tmr_i), .rti_i(rti_i),
        .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .busy_o(busy_o),
        .pc_load_o(pc_load_o), .pc_o(pc_o), .sr_load_o(sr_load_o), .sr_o(sr_o),
        .sp_wr_o(sp_wr_o), .sp_o(sp_o), .vec_addr_o(vec_addr_o), .depth_o(depth_o)
    );

    // byte memory model, read data one cycle after the strobe
    always @(posedge clk) begin
        if (mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
        if (mem_re_o) mem_rdata_i <= mem[mem_addr_o[7:0]];
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); step_i = 1'b1;
        end
        @(negedge clk); step_i = 1'b0;
    endtask

    task automatic expect_idle(input int n, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (busy_o || pc_load_o) seen++;
        end
        chk(seen == 0, req, "no entry expected", seen, 0);
    endtask

    task automatic enter_check(input logic [15:0] exp_vec, input logic [15:0] exp_vaddr,
                               input string req);
        int busy_cnt = 0;
        int guard = 0;
        logic [15:0] sp0, sr0, pc0;
        sp0 = sp_i; sr0 = sr_i; pc0 = pc_i;
        do begin
            @(negedge clk);
            if (busy_o) busy_cnt++;
            guard++;
        end while (!pc_load_o && guard < 80);
        chk(pc_load_o, req, "entry completed", int'(pc_load_o), 1);
        chk(busy_cnt == 4, "R6", "busy cycles", busy_cnt, 4);
        chk(pc_o == exp_vec, "R7", "handler pc", pc_o, exp_vec);
        chk(vec_addr_o == exp_vaddr, req, "vector table address", vec_addr_o, exp_vaddr);
        chk(sp_wr_o && sp_o == sp0 - 16'd4, "R7", "stack pointer", sp_o, sp0 - 16'd4);
        chk({mem[8'(sp0-16'd2)], mem[8'(sp0-16'd1)]} == sr0, "R6", "saved status",
            {mem[8'(sp0-16'd2)], mem[8'(sp0-16'd1)]}, sr0);
        chk({mem[8'(sp0-16'd4)], mem[8'(sp0-16'd3)]} == pc0, "R6", "saved pc",
            {mem[8'(sp0-16'd4)], mem[8'(sp0-16'd3)]}, pc0);
        sp_i = sp_o;
        @(negedge clk);
        chk(depth_o == 4'd1, "R8", "depth after entry", depth_o, 1);
    endtask

    task automatic return_check(input logic [15:0] exp_pc, input logic [15:0] exp_sr,
                                input logic [DEPTH_W-1:0] exp_depth);
        int guard = 0;
        logic [15:0] sp0;
        sp0 = sp_i;
        @(negedge clk); rti_i = 1'b1;
        @(negedge clk); rti_i = 1'b0;
        while (!sr_load_o && guard < 40) begin
            @(negedge clk); guard++;
        end
        chk(sr_load_o && pc_load_o, "R9", "return strobes", int'(sr_load_o), 1);
        chk(pc_o == exp_pc, "R9", "restored pc", pc_o, exp_pc);
        chk(sr_o == exp_sr, "R9", "restored status", sr_o, exp_sr);
        chk(sp_o == sp0 + 16'd4, "R9", "stack pointer after pops", sp_o, sp0 + 16'd4);
        sp_i = sp_o;
        @(negedge clk);
        chk(depth_o == exp_depth, "R9", "depth after return", depth_o, exp_depth);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(!mem_we_o && !mem_re_o && !busy_o, "R1", "memory port idle", int'(busy_o), 0);
        chk(!pc_load_o && !sr_load_o && !sp_wr_o, "R1", "strobes low", int'(pc_load_o), 0);
        chk(depth_o == '0, "R1", "depth at reset", depth_o, 0);
    endtask

    task automatic t_mask;
        sr_i = 16'h0300; pc_i = 16'h1234; pri_tmr_i = 8'h00;
        pri_tx_i = 8'hBF; tx_req_i = 1'b1;          // level 3 with noise bits: R2, R3 equal
        expect_idle(12, "R3");
        pri_tx_i = 8'h4F;                            // level 4 above mask 3
        enter_check(vec_tx_i, 16'h0084, "R2");
        pri_tx_i = 8'hFF;
        expect_idle(10, "R8");
        chk(depth_o == 4'd1, "R8", "depth held while nested", depth_o, 1);
        tx_req_i = 1'b0;
        return_check(16'h1234, 16'h0300, 4'd0);
        return_check({mem[8'(sp_i)], mem[8'(sp_i+16'd1)]},
                     {mem[8'(sp_i+16'd2)], mem[8'(sp_i+16'd3)]}, 4'd0); // R9 floor at zero
        sp_i = 16'h00C0;
    endtask

    task automatic t_timer;
        sr_i = 16'h0000; pc_i = 16'h2468; pri_tmr_i = 8'h5A; tx_req_i = 1'b0;
        steps(PERIOD - 1);
        expect_idle(5, "R5");
        steps(1);
        enter_check(vec_tmr_i, 16'h0042, "R5");
        return_check(16'h2468, 16'h0000, 4'd0);
        steps(PERIOD - 1);
        expect_idle(5, "R5");                        // count restarted from zero
    endtask

    task automatic t_arb;
        sr_i = 16'h0700; pc_i = 16'h0F0F;
        steps(1);                                    // timer now pending, masked
        expect_idle(4, "R3");
        tx_req_i = 1'b1; pri_tx_i = 8'h20; pri_tmr_i = 8'h60;
        sr_i = 16'h0000;
        enter_check(vec_tmr_i, 16'h0042, "R4");      // higher timer level wins
        return_check(16'h0F0F, 16'h0000, 4'd0);
        enter_check(vec_tx_i, 16'h0084, "R4");       // serial still asking
        tx_req_i = 1'b0;
        return_check(16'h0F0F, 16'h0000, 4'd0);
        sr_i = 16'h0700;
        steps(PERIOD);
        pri_tx_i = 8'h40; pri_tmr_i = 8'hC0; pc_i = 16'h7777;
        tx_req_i = 1'b1; sr_i = 16'h0100;
        enter_check(vec_tx_i, 16'h0084, "R4");       // tie goes to serial
        tx_req_i = 1'b0;
        return_check(16'h7777, 16'h0100, 4'd0);
        enter_check(vec_tmr_i, 16'h0042, "R5");      // timer stayed pending
        return_check(16'h7777, 16'h0100, 4'd0);
    endtask

    task automatic t_rti_first;
        pc_i = 16'h4321; sr_i = 16'h0000; pri_tx_i = 8'h70;
        mem[8'h40] = 8'hAB; mem[8'h41] = 8'hCD; mem[8'h42] = 8'h05; mem[8'h43] = 8'h00;
        sp_i = 16'h0040;
        @(negedge clk); rti_i = 1'b1; tx_req_i = 1'b1;
        @(negedge clk); rti_i = 1'b0;
        chk(mem_re_o && !busy_o, "R10", "return served first", int'(mem_re_o), 1);
        tx_req_i = 1'b0;
        while (!sr_load_o) @(negedge clk);
        chk(pc_o == 16'hABCD, "R10", "popped pc", pc_o, 16'hABCD);
        chk(sr_o == 16'h0500, "R10", "popped status", sr_o, 16'h0500);
        sp_i = 16'h00C0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mask();
        t_timer();
        t_arb();
        t_rti_first();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule